// File: doc/BRIEF.md
# Sleep and wake-event control

This block is the power-management control point of a processor core. It keeps a small sleep-control register and a one-bit event latch, and it decides when a core that has executed a wait-for-event or wait-for-interrupt instruction is put to sleep and when it is woken again. The core's pipeline raises `wfe_req` or `wfi_req` for one cycle. The block then raises `sleeping` and, when deep sleep is selected, `deep_sleep`. When a qualifying wake source arrives, both drop and `wake` pulses for one cycle.

The register has security banking. The send-event-on-pend bit and the sleep-on-exit bit each exist once per security state. The deep-sleep bit is a single copy seen by both states. A lock bit, usable only from the secure state, hides the deep-sleep bit from the non-secure state. The `sec_state` input gives the state of a register access. It also chooses which bank governs behaviour.

Events have two paths. An event or a new pending interrupt that arrives while the core is not waiting for an event is remembered in the latch, and the next wait-for-event consumes it. A return from a handler to thread mode puts the core to sleep when sleep-on-exit is set.

Top module: `slp_wake_ctl`

## Requirements
- R1: After reset, `sleeping`, `deep_sleep` and `wake` are 0, and the register reads 0x00000000 from both security states.
- R2: Register bit 4 (send-event-on-pend) and bit 1 (sleep-on-exit) have one copy per security state. A write changes only the copy of the writer's state (`sec_state`=1 secure, 0 non-secure), and a read returns the copy of the reader's state. Bits 0 and 31:5 always read 0.
- R3: Register bit 2 (deep sleep) has a single copy shared by both states. While the lock is clear, a write from either state sets it and a read from either state shows it.
- R4: Register bit 3 (deep-sleep lock) is written only from the secure state. From the non-secure state it always reads 0 and writes to it are ignored.
- R5: While bit 3 is 1, a non-secure read returns 0 in bit 2, and non-secure writes leave bit 2 unchanged.
- R6: A wait-for-event with an empty latch and no event in the same cycle raises `sleeping` from the next cycle. An SEV pulse, an external event, or a pending and enabled interrupt then drops `sleeping` and raises `wake` for one cycle, one cycle after the waking input.
- R7: An event that arrives while the core is awake or in wait-for-interrupt sleep sets the latch. The next wait-for-event clears the latch and gives a `wake` pulse one cycle later without raising `sleeping`. A further wait-for-event then sleeps.
- R8: An event in the same cycle as a wait-for-event request with an empty latch counts as already latched. The core does not sleep, `wake` pulses, and the latch is left clear.
- R9: While the active bank's bit 4 is 0, a disabled interrupt that becomes pending does not wake a wait-for-event sleep. While it is 1, it does.
- R10: Wait-for-interrupt sleep ends only on a pending and enabled interrupt. SEV pulses and external events do not end it.
- R11: A handler-to-thread return indication with the active bank's bit 1 set enters wait-for-interrupt sleep in the next cycle. With bit 1 clear it has no effect.
- R12: `deep_sleep` is 1 exactly when `sleeping` is 1 and register bit 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_state | input | 1 | Security state of the core and of a register access (1 secure) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, as seen from `sec_state` |
| irq_pend | input | N_IRQ | Interrupt pending flags |
| irq_en | input | N_IRQ | Interrupt enable flags |
| ext_evt | input | 1 | External event pulse |
| sev_pulse | input | 1 | Send-event instruction pulse |
| wfe_req | input | 1 | Wait-for-event request pulse |
| wfi_req | input | 1 | Wait-for-interrupt request pulse |
| exc_ret_thread | input | 1 | Handler-to-thread return indication |
| sleeping | output | 1 | Core is asleep |
| deep_sleep | output | 1 | Core is asleep in deep sleep |
| wake | output | 1 | One-cycle wake pulse |

## Verification
The case that needs care is an event landing in the same cycle as a wait-for-event request. The latch consume path and the sleep entry path then both compete for that cycle. The bench drives an SEV pulse together with a wait-for-event request while the latch is empty. It expects the core to stay awake with a wake pulse. A second request must then sleep, which shows the event was consumed and not left in the latch.

// File: rtl/slp_wake_pkg.sv
package slp_wake_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_WFE   = 2'd1,
    ST_WFI   = 2'd2
  } slp_state_e;

  // Field positions decoded by software
  localparam int unsigned B_SOE  = 1;
  localparam int unsigned B_DEEP = 2;
  localparam int unsigned B_LOCK = 3;
  localparam int unsigned B_SOP  = 4;
endpackage

// File: rtl/slp_cfg_regs.sv
module slp_cfg_regs
  import slp_wake_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_state,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          sop_act,
  output logic          soe_act,
  output logic          deep_mode
);
  logic sop_s, sop_ns, soe_s, soe_ns, deep_q, lock_q;
  logic sop_s_n, sop_ns_n, soe_s_n, soe_ns_n, deep_n, lock_n;
  logic wr_sec, wr_nsec;
  logic unused_wbits;

  assign unused_wbits = ^{wdata[DW-1:B_SOP+1], wdata[0]};
  assign wr_sec  = wr_en &  sec_state;
  assign wr_nsec = wr_en & ~sec_state;

  always_comb begin
    sop_s_n  = wr_sec  ? wdata[B_SOP]  : sop_s;
    soe_s_n  = wr_sec  ? wdata[B_SOE]  : soe_s;
    sop_ns_n = wr_nsec ? wdata[B_SOP]  : sop_ns;
    soe_ns_n = wr_nsec ? wdata[B_SOE]  : soe_ns;
    lock_n   = wr_sec  ? wdata[B_LOCK] : lock_q;
    deep_n   = (wr_sec || (wr_nsec && !lock_q)) ? wdata[B_DEEP] : deep_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sop_s  <= 1'b0;
      sop_ns <= 1'b0;
      soe_s  <= 1'b0;
      soe_ns <= 1'b0;
      lock_q <= 1'b0;
      deep_q <= 1'b0;
    end else if (wr_en) begin
      sop_s  <= sop_s_n;
      sop_ns <= sop_ns_n;
      soe_s  <= soe_s_n;
      soe_ns <= soe_ns_n;
      lock_q <= lock_n;
      deep_q <= deep_n;
    end
  end

  always_comb begin
    rdata = '0;
    if (sec_state) begin
      rdata[B_SOP]  = sop_s;
      rdata[B_SOE]  = soe_s;
      rdata[B_LOCK] = lock_q;
      rdata[B_DEEP] = deep_q;
    end else begin
      rdata[B_SOP]  = sop_ns;
      rdata[B_SOE]  = soe_ns;
      rdata[B_DEEP] = deep_q & ~lock_q;
    end
  end

  assign sop_act   = sec_state ? sop_s : sop_ns;
  assign soe_act   = sec_state ? soe_s : soe_ns;
  assign deep_mode = deep_q;
endmodule

// File: rtl/slp_evt_src.sv
module slp_evt_src #(
  parameter int unsigned N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             sop_act,
  input  logic             ext_evt,
  input  logic             sev_pulse,
  output logic             evt_src,
  output logic             irq_live
);
  logic [N_IRQ-1:0] pend_q;
  logic [N_IRQ-1:0] pend_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= irq_pend;
  end

  assign pend_rise = irq_pend & ~pend_q;
  assign evt_src   = sev_pulse | ext_evt | (sop_act & (|pend_rise));
  assign irq_live  = |(irq_pend & irq_en);
endmodule

// File: rtl/slp_core_fsm.sv
module slp_core_fsm
  import slp_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wfe_req,
  input  logic       wfi_req,
  input  logic       exit_req,
  input  logic       evt_src,
  input  logic       irq_live,
  output slp_state_e st_q,
  output logic       latch_q,
  output logic       wake_q
);
  slp_state_e st_n;
  logic       latch_n, wake_n;

  always_comb begin
    st_n    = st_q;
    latch_n = latch_q;
    wake_n  = 1'b0;
    case (st_q)
      ST_AWAKE: begin
        if (wfe_req) begin
          if (latch_q || evt_src) begin
            latch_n = 1'b0;
            wake_n  = 1'b1;
          end else begin
            st_n = ST_WFE;
          end
        end else begin
          if (evt_src) latch_n = 1'b1;
          if (wfi_req || exit_req) st_n = ST_WFI;
        end
      end
      ST_WFE: begin
        if (evt_src || irq_live) begin
          st_n   = ST_AWAKE;
          wake_n = 1'b1;
        end
      end
      ST_WFI: begin
        if (evt_src) latch_n = 1'b1;
        if (irq_live) begin
          st_n   = ST_AWAKE;
          wake_n = 1'b1;
        end
      end
      default: st_n = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_AWAKE;
      latch_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      latch_q <= latch_n;
      wake_q  <= wake_n;
    end
  end
endmodule

// File: rtl/slp_wake_ctl.sv
module slp_wake_ctl
  import slp_wake_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_state,
  input  logic             reg_wr_en,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             ext_evt,
  input  logic             sev_pulse,
  input  logic             wfe_req,
  input  logic             wfi_req,
  input  logic             exc_ret_thread,
  output logic             sleeping,
  output logic             deep_sleep,
  output logic             wake
);
  logic       sop_act, soe_act, deep_mode;
  logic       evt_src, irq_live;
  logic       evt_latch;
  slp_state_e st_cur;

  slp_cfg_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .sec_state(sec_state),
    .wr_en(reg_wr_en), .wdata(reg_wdata), .rdata(reg_rdata),
    .sop_act(sop_act), .soe_act(soe_act), .deep_mode(deep_mode)
  );

  slp_evt_src #(.N_IRQ(N_IRQ)) u_evt (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_en(irq_en),
    .sop_act(sop_act), .ext_evt(ext_evt), .sev_pulse(sev_pulse),
    .evt_src(evt_src), .irq_live(irq_live)
  );

  slp_core_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wfe_req(wfe_req), .wfi_req(wfi_req),
    .exit_req(exc_ret_thread & soe_act), .evt_src(evt_src),
    .irq_live(irq_live), .st_q(st_cur), .latch_q(evt_latch), .wake_q(wake)
  );

  assign sleeping   = (st_cur != ST_AWAKE);
  assign deep_sleep = sleeping & deep_mode;
endmodule

// File: rtl/slp_wake_chk.sv
module slp_wake_chk
  import slp_wake_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned N_IRQ = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sec_state,
  input logic [DW-1:0]    reg_rdata,
  input logic [N_IRQ-1:0] irq_pend,
  input logic [N_IRQ-1:0] irq_en,
  input logic             wfe_req,
  input logic             sleeping,
  input logic             deep_sleep,
  input logic             wake,
  input logic             evt_latch,
  input slp_state_e       st
);
  assert_deep_needs_sleep_R12: assert property (@(posedge clk) disable iff (!rst_n)
    deep_sleep |-> sleeping);

  assert_wake_while_awake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> !sleeping);

  assert_sleep_end_pulses_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleeping) |-> wake);

  assert_latch_consumed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleeping && wfe_req && evt_latch) |=> (wake && !sleeping && !evt_latch));

  assert_nsec_lock_hidden_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_state |-> !reg_rdata[B_LOCK]);

  assert_wfi_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WFI && !(|(irq_pend & irq_en))) |=> sleeping);
endmodule

bind slp_wake_ctl slp_wake_chk #(.DW(DW), .N_IRQ(N_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_state(sec_state), .reg_rdata(reg_rdata),
  .irq_pend(irq_pend), .irq_en(irq_en), .wfe_req(wfe_req),
  .sleeping(sleeping), .deep_sleep(deep_sleep), .wake(wake),
  .evt_latch(evt_latch), .st(st_cur)
);

// File: tb/slp_wake_ctl_tb_top.sv
`timescale 1ns/1ps
module slp_wake_ctl_tb_top;
  localparam int DW = 32;
  localparam int NI = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sec_state, reg_wr_en;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic [NI-1:0] irq_pend, irq_en;
  logic          ext_evt, sev_pulse, wfe_req, wfi_req, exc_ret_thread;
  logic          sleeping, deep_sleep, wake;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  slp_wake_ctl #(.DW(DW), .N_IRQ(NI)) dut_i (
    .clk(clk), .rst_n(rst_n), .sec_state(sec_state), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pend(irq_pend),
    .irq_en(irq_en), .ext_evt(ext_evt), .sev_pulse(sev_pulse),
    .wfe_req(wfe_req), .wfi_req(wfi_req), .exc_ret_thread(exc_ret_thread),
    .sleeping(sleeping), .deep_sleep(deep_sleep), .wake(wake)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk_out(input string tag, input logic s, input logic d, input logic w);
    check({tag, " sleeping"}, {31'd0, sleeping}, {31'd0, s});
    check({tag, " deep_sleep"}, {31'd0, deep_sleep}, {31'd0, d});
    check({tag, " wake"}, {31'd0, wake}, {31'd0, w});
  endtask

  task automatic reg_write(input logic sec, input logic [31:0] val);
    sec_state = sec; reg_wdata = val; reg_wr_en = 1'b1;
    step();
    reg_wr_en = 1'b0; sec_state = 1'b1;
  endtask

  task automatic reg_check(input string tag, input logic sec, input logic [31:0] exp);
    sec_state = sec; #1;
    check(tag, reg_rdata, exp);
    sec_state = 1'b1;
  endtask

  task automatic pulse_sev();  sev_pulse = 1'b1; step(); sev_pulse = 1'b0; endtask
  task automatic pulse_ext();  ext_evt = 1'b1;   step(); ext_evt = 1'b0;   endtask
  task automatic pulse_wfe();  wfe_req = 1'b1;   step(); wfe_req = 1'b0;   endtask
  task automatic pulse_wfi();  wfi_req = 1'b1;   step(); wfi_req = 1'b0;   endtask

  task automatic irq_on(input int idx, input logic en);
    irq_pend[idx] = 1'b1; irq_en[idx] = en; step();
  endtask
  task automatic irq_off();
    irq_pend = '0; irq_en = '0; step();
  endtask

  task automatic t_reset();
    chk_out("R1 reset", 1'b0, 1'b0, 1'b0);
    reg_check("R1 secure read", 1'b1, 32'h0);
    reg_check("R1 nonsecure read", 1'b0, 32'h0);
  endtask

  task automatic t_banking();
    reg_write(1'b1, 32'hFFFF_FFF3);
    reg_check("R2 secure bank", 1'b1, 32'h12);
    reg_check("R2 nonsecure isolated", 1'b0, 32'h0);
    reg_write(1'b0, 32'h12);
    reg_check("R2 nonsecure bank", 1'b0, 32'h12);
    reg_write(1'b0, 32'h0);
    reg_check("R2 nonsecure cleared", 1'b0, 32'h0);
    reg_check("R2 secure kept", 1'b1, 32'h12);
    reg_write(1'b1, 32'h0);
  endtask

  task automatic t_deep_shared();
    reg_write(1'b0, 32'h04);
    reg_check("R3 nonsecure write seen secure", 1'b1, 32'h04);
    reg_write(1'b1, 32'h00);
    reg_check("R3 secure clear seen nonsecure", 1'b0, 32'h00);
  endtask

  task automatic t_lock();
    reg_write(1'b0, 32'h08);
    reg_check("R4 nonsecure lock write ignored", 1'b1, 32'h00);
    reg_write(1'b1, 32'h08);
    reg_check("R4 lock reads zero nonsecure", 1'b0, 32'h00);
    reg_check("R4 lock visible secure", 1'b1, 32'h08);
    reg_write(1'b1, 32'h0C);
    reg_check("R5 deep hidden nonsecure", 1'b0, 32'h00);
    reg_write(1'b0, 32'h00);
    reg_check("R5 nonsecure deep write ignored", 1'b1, 32'h0C);
    reg_write(1'b1, 32'h00);
  endtask

  task automatic t_wfe_wake();
    for (int src = 0; src < 3; src++) begin
      pulse_wfe();
      chk_out("R6 wfe entered", 1'b1, 1'b0, 1'b0);
      step();
      chk_out("R6 wfe holds", 1'b1, 1'b0, 1'b0);
      if (src == 0) pulse_sev();
      else if (src == 1) pulse_ext();
      else irq_on(0, 1'b1);
      chk_out("R6 wfe woken", 1'b0, 1'b0, 1'b1);
      if (src == 2) irq_off(); else step();
      chk_out("R6 wake single cycle", 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic t_latch();
    pulse_ext();
    chk_out("R7 event while awake", 1'b0, 1'b0, 1'b0);
    pulse_wfe();
    chk_out("R7 latched wfe returns", 1'b0, 1'b0, 1'b1);
    pulse_wfe();
    chk_out("R7 latch was cleared", 1'b1, 1'b0, 1'b0);
    pulse_sev();
    chk_out("R7 woken", 1'b0, 1'b0, 1'b1);
    pulse_wfi();
    chk_out("R10 wfi entered", 1'b1, 1'b0, 1'b0);
    pulse_sev();
    chk_out("R10 sev ignored in wfi", 1'b1, 1'b0, 1'b0);
    pulse_ext();
    chk_out("R10 ext ignored in wfi", 1'b1, 1'b0, 1'b0);
    irq_on(1, 1'b0);
    chk_out("R10 disabled irq ignored in wfi", 1'b1, 1'b0, 1'b0);
    irq_en[1] = 1'b1; step();
    chk_out("R10 enabled irq wakes wfi", 1'b0, 1'b0, 1'b1);
    irq_off();
    pulse_wfe();
    chk_out("R7 event during wfi latched", 1'b0, 1'b0, 1'b1);
    step();
  endtask

  task automatic t_same_cycle();
    wfe_req = 1'b1; sev_pulse = 1'b1; step();
    wfe_req = 1'b0; sev_pulse = 1'b0;
    chk_out("R8 event with wfe no sleep", 1'b0, 1'b0, 1'b1);
    pulse_wfe();
    chk_out("R8 latch left clear", 1'b1, 1'b0, 1'b0);
    pulse_ext();
    chk_out("R8 woken", 1'b0, 1'b0, 1'b1);
    step();
  endtask

  task automatic t_sevonpend();
    reg_write(1'b1, 32'h00);
    pulse_wfe();
    irq_on(3, 1'b0);
    chk_out("R9 disabled pend no wake", 1'b1, 1'b0, 1'b0);
    irq_off();
    pulse_ext();
    chk_out("R9 woken by ext", 1'b0, 1'b0, 1'b1);
    reg_write(1'b1, 32'h10);
    pulse_wfe();
    chk_out("R9 asleep", 1'b1, 1'b0, 1'b0);
    irq_on(3, 1'b0);
    chk_out("R9 disabled pend wakes", 1'b0, 1'b0, 1'b1);
    irq_off();
    reg_write(1'b1, 32'h00);
  endtask

  task automatic t_exit();
    reg_write(1'b1, 32'h02);
    exc_ret_thread = 1'b1; step(); exc_ret_thread = 1'b0;
    chk_out("R11 sleep on exit", 1'b1, 1'b0, 1'b0);
    irq_on(2, 1'b1);
    chk_out("R11 exit sleep woken", 1'b0, 1'b0, 1'b1);
    irq_off();
    reg_write(1'b1, 32'h00);
    exc_ret_thread = 1'b1; step(); exc_ret_thread = 1'b0;
    chk_out("R11 no sleep when clear", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_deep();
    reg_write(1'b1, 32'h04);
    chk_out("R12 awake no deep", 1'b0, 1'b0, 1'b0);
    pulse_wfi();
    chk_out("R12 deep while asleep", 1'b1, 1'b1, 1'b0);
    irq_on(5, 1'b1);
    chk_out("R12 deep drops on wake", 1'b0, 1'b0, 1'b1);
    irq_off();
    reg_write(1'b1, 32'h00);
    pulse_wfi();
    chk_out("R12 plain sleep", 1'b1, 1'b0, 1'b0);
    irq_on(5, 1'b1);
    irq_off();
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sec_state = 1'b1; reg_wr_en = 1'b0; reg_wdata = '0;
    irq_pend = '0; irq_en = '0; ext_evt = 1'b0; sev_pulse = 1'b0;
    wfe_req = 1'b0; wfi_req = 1'b0; exc_ret_thread = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_banking();
    t_deep_shared();
    t_lock();
    t_wfe_wake();
    t_latch();
    t_same_cycle();
    t_sevonpend();
    t_exit();
    t_deep();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule